// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of a few lines in one private cache. The cache sits on a snooping bus next to peer caches. Each line is direct-mapped by the low bits of the line address, and each holds one of four states: invalid, shared, exclusive or modified. The block serves local reads and writes. It also watches snooped bus transactions and answers them in the same cycle.

For a local access that needs the bus, the block raises a bus request with an operation code and a line address. It holds that request until the bus model grants it, and the grant completes the transaction in that cycle. A modified line that loses its place to a conflicting fill is first written back with a write-back operation. A snooped read that hits a modified line reports that this cache will supply the dirty data. A snooped read of any valid line reports that a copy is shared.

The snoop side always takes effect before the local side. A local request that arrives in the same cycle as a snoop on the same line therefore sees the state the snoop leaves behind. The environment must never assert a snoop in a cycle in which it grants this block's own request, because the bus carries one transaction at a time.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid. No bus request is raised, and no snoop to any address reports shared or dirty.
- R2: A local read miss issues a bus read (bus_op 0). At the grant it fills the line as exclusive if bus_peer_shared is low, and as shared if it is high, and completes. The cycle after completion holds no bus request.
- R3: A local write miss issues a read-invalidate (bus_op 1). At the grant the line becomes modified and the write completes.
- R4: A local write to a shared line issues an invalidate (bus_op 2) and becomes modified only at its grant. If a snoop invalidates the line before that grant, the write retries as a read-invalidate (bus_op 1).
- R5: A local read hit in any valid state completes in the cycle it is presented, without a bus request. So does a local write hit to a modified line. A local write to an exclusive line also completes in that cycle without a bus request, and the line becomes modified.
- R6: A snooped read (snp_op 0) that hits a valid line asserts snp_shared and moves the line to shared. It also asserts snp_dirty if the line was modified.
- R7: A snooped read-invalidate (snp_op 1) or invalidate (snp_op 2) that hits a valid line moves it to invalid and never asserts snp_shared. It asserts snp_dirty if the line was modified.
- R8: A miss whose direct-mapped slot holds a modified line of another address first issues a write-back (bus_op 3) carrying the victim's line address, then the fill. A clean victim is replaced with no write-back.
- R9: A snoop whose address does not match the tag held in its slot gives no response and leaves that line's state unchanged.
- R10: When a snoop and a local request target the same line in one cycle, the snoop's transition is applied first and the local request acts on the resulting state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| lreq_valid | input | 1 | Local access present; held until lreq_done |
| lreq_write | input | 1 | Local access is a write |
| lreq_addr | input | ADDR_W | Local line address |
| lreq_done | output | 1 | Local access completes this cycle |
| bus_req | output | 1 | Bus transaction requested |
| bus_op | output | 2 | 0 read, 1 read-invalidate, 2 invalidate, 3 write-back |
| bus_addr | output | ADDR_W | Line address of the requested transaction |
| bus_gnt | input | 1 | Bus grant; the requested transaction completes this cycle |
| bus_peer_shared | input | 1 | Peers hold the line, valid with a read grant |
| snp_valid | input | 1 | Snooped transaction present |
| snp_op | input | 2 | 0 read, 1 read-invalidate, 2 invalidate, 3 none |
| snp_addr | input | ADDR_W | Snooped line address |
| snp_shared | output | 1 | This cache keeps a copy after the snooped read |
| snp_dirty | output | 1 | This cache supplies modified data |

## Verification
The snoop path and the local request path can act on the same line in one cycle. The bench provokes this in three ways. It drives a snooped read in the cycle a write reaches an exclusive line, and the write must then issue an invalidate rather than finish silently. It drives a snooped read-invalidate alongside a read hit, and the read must then fetch the line again. It drives a read-invalidate snoop between an invalidate request and its grant, and the write must switch to a read-invalidate. Each case is judged by the snoop response sampled in that cycle and by the set of bus operations the request goes on to issue.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        BOP_RD  = 2'd0,
        BOP_RDX = 2'd1,
        BOP_INV = 2'd2,
        BOP_WB  = 2'd3
    } bus_op_e;

    typedef enum logic [1:0] {
        SOP_RD   = 2'd0,
        SOP_RDX  = 2'd1,
        SOP_INV  = 2'd2,
        SOP_NONE = 2'd3
    } snp_op_e;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WB   = 2'd1,
        FS_FILL = 2'd2,
        FS_UPG  = 2'd3
    } fsm_e;

endpackage

// File: rtl/mesi_line_array.sv
module mesi_line_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int TAG_W     = 6,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              snp_upd_en,
    input  logic [IDX_W-1:0]                  snp_upd_idx,
    input  line_st_e                          snp_upd_st,
    input  logic                              loc_upd_en,
    input  logic [IDX_W-1:0]                  loc_upd_idx,
    input  line_st_e                          loc_upd_st,
    input  logic [TAG_W-1:0]                  loc_upd_tag,
    output line_st_e [NUM_LINES-1:0]          st_o,
    output logic [NUM_LINES-1:0][TAG_W-1:0]   tag_o
);

    typedef struct packed {
        line_st_e [NUM_LINES-1:0]        st;
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
    } arr_t;

    arr_t arr_d, arr_q;

    line_st_e         st_nx  [NUM_LINES];
    logic [TAG_W-1:0] tag_nx [NUM_LINES];

    // Per-line next value: the snoop transition first, then the local update.
    // The local update is derived from the post-snoop view, so it takes precedence.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_comb begin
            st_nx[g]  = arr_q.st[g];
            tag_nx[g] = arr_q.tag[g];
            if (snp_upd_en && (snp_upd_idx == IDX_W'(g))) begin
                st_nx[g] = snp_upd_st;
            end
            if (loc_upd_en && (loc_upd_idx == IDX_W'(g))) begin
                st_nx[g]  = loc_upd_st;
                tag_nx[g] = loc_upd_tag;
            end
        end
    end

    always_comb begin
        arr_d = arr_q;
        for (int i = 0; i < NUM_LINES; i++) begin
            arr_d.st[i]  = st_nx[i];
            arr_d.tag[i] = tag_nx[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LINES; i++) begin
                arr_q.st[i]  <= ST_I;
                arr_q.tag[i] <= '0;
            end
        end else begin
            arr_q <= arr_d;
        end
    end

    assign st_o  = arr_q.st;
    assign tag_o = arr_q.tag;

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic             snp_valid,
    input  logic [1:0]       snp_op,
    input  logic [TAG_W-1:0] snp_tag,
    input  line_st_e         line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             hit,
    output logic             resp_shared,
    output logic             resp_dirty,
    output line_st_e         nxt_st
);

    snp_op_e op;
    logic    known_op;

    always_comb begin
        op          = snp_op_e'(snp_op);
        known_op    = (op == SOP_RD) || (op == SOP_RDX) || (op == SOP_INV);
        hit         = snp_valid && known_op && (line_st != ST_I) && (line_tag == snp_tag);
        resp_dirty  = hit && (line_st == ST_M);
        resp_shared = hit && (op == SOP_RD);
        nxt_st      = line_st;
        if (hit) begin
            nxt_st = (op == SOP_RD) ? ST_S : ST_I;
        end
    end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int IDX_W  = 2,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_valid,
    input  logic              lreq_write,
    input  logic [ADDR_W-1:0] lreq_addr,
    input  line_st_e          view_st,
    input  logic [TAG_W-1:0]  view_tag,
    input  logic              bus_gnt,
    input  logic              bus_peer_shared,
    output logic              lreq_done,
    output logic              bus_req,
    output bus_op_e           bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              upd_en,
    output line_st_e          upd_st,
    output logic [TAG_W-1:0]  upd_tag
);

    typedef struct packed {
        fsm_e st;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] lidx;
    logic [TAG_W-1:0] ltag;
    logic             lhit;

    assign lidx = lreq_addr[IDX_W-1:0];
    assign ltag = lreq_addr[ADDR_W-1:IDX_W];
    assign lhit = (view_st != ST_I) && (view_tag == ltag);

    always_comb begin
        ctl_d     = ctl_q;
        lreq_done = 1'b0;
        bus_req   = 1'b0;
        bus_op    = BOP_RD;
        bus_addr  = lreq_addr;
        upd_en    = 1'b0;
        upd_st    = view_st;
        upd_tag   = view_tag;

        unique case (ctl_q.st)
            FS_IDLE: begin
                if (lreq_valid) begin
                    if (lhit) begin
                        if (!lreq_write || (view_st == ST_M)) begin
                            lreq_done = 1'b1;
                        end else if (view_st == ST_E) begin
                            lreq_done = 1'b1;
                            upd_en    = 1'b1;
                            upd_st    = ST_M;
                        end else begin
                            ctl_d.st = FS_UPG;
                        end
                    end else if (view_st == ST_M) begin
                        ctl_d.st = FS_WB;
                    end else begin
                        ctl_d.st = FS_FILL;
                    end
                end
            end

            FS_WB: begin
                if (view_st == ST_M) begin
                    bus_req  = 1'b1;
                    bus_op   = BOP_WB;
                    bus_addr = {view_tag, lidx};
                    if (bus_gnt) begin
                        upd_en   = 1'b1;
                        upd_st   = ST_I;
                        ctl_d.st = FS_FILL;
                    end
                end else begin
                    // Victim lost its dirty data to a snoop: nothing to write back.
                    ctl_d.st = FS_FILL;
                end
            end

            FS_FILL: begin
                bus_req = 1'b1;
                bus_op  = lreq_write ? BOP_RDX : BOP_RD;
                if (bus_gnt) begin
                    upd_en    = 1'b1;
                    upd_tag   = ltag;
                    if (lreq_write) begin
                        upd_st = ST_M;
                    end else begin
                        upd_st = bus_peer_shared ? ST_S : ST_E;
                    end
                    lreq_done = 1'b1;
                    ctl_d.st  = FS_IDLE;
                end
            end

            FS_UPG: begin
                if (lhit && (view_st == ST_S)) begin
                    bus_req = 1'b1;
                    bus_op  = BOP_INV;
                    if (bus_gnt) begin
                        upd_en    = 1'b1;
                        upd_st    = ST_M;
                        lreq_done = 1'b1;
                        ctl_d.st  = FS_IDLE;
                    end
                end else begin
                    // Copy was invalidated before the grant: fetch with ownership.
                    ctl_d.st = FS_FILL;
                end
            end

            default: ctl_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.st <= FS_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lreq_valid,
    input  logic              lreq_write,
    input  logic [ADDR_W-1:0] lreq_addr,
    output logic              lreq_done,
    output logic              bus_req,
    output logic [1:0]        bus_op,
    output logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_gnt,
    input  logic              bus_peer_shared,
    input  logic              snp_valid,
    input  logic [1:0]        snp_op,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_dirty
);

    localparam int IDX_W = $clog2(NUM_LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    line_st_e [NUM_LINES-1:0]        st;
    logic [NUM_LINES-1:0][TAG_W-1:0] tag;

    logic [IDX_W-1:0] sidx, lidx;
    logic [TAG_W-1:0] stag;
    logic             s_hit;
    line_st_e         s_nxt;

    line_st_e         view_st;
    logic [TAG_W-1:0] view_tag;

    logic             upd_en;
    line_st_e         upd_st;
    logic [TAG_W-1:0] upd_tag;
    bus_op_e          op_e;

    assign sidx = snp_addr[IDX_W-1:0];
    assign stag = snp_addr[ADDR_W-1:IDX_W];
    assign lidx = lreq_addr[IDX_W-1:0];

    mesi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_valid   (snp_valid),
        .snp_op      (snp_op),
        .snp_tag     (stag),
        .line_st     (st[sidx]),
        .line_tag    (tag[sidx]),
        .hit         (s_hit),
        .resp_shared (snp_shared),
        .resp_dirty  (snp_dirty),
        .nxt_st      (s_nxt)
    );

    // Local side sees the slot as the snoop of this cycle leaves it.
    always_comb begin
        view_tag = tag[lidx];
        view_st  = (s_hit && (sidx == lidx)) ? s_nxt : st[lidx];
    end

    mesi_req_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .lreq_valid      (lreq_valid),
        .lreq_write      (lreq_write),
        .lreq_addr       (lreq_addr),
        .view_st         (view_st),
        .view_tag        (view_tag),
        .bus_gnt         (bus_gnt),
        .bus_peer_shared (bus_peer_shared),
        .lreq_done       (lreq_done),
        .bus_req         (bus_req),
        .bus_op          (op_e),
        .bus_addr        (bus_addr),
        .upd_en          (upd_en),
        .upd_st          (upd_st),
        .upd_tag         (upd_tag)
    );

    assign bus_op = op_e;

    mesi_line_array #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_lines (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_upd_en  (s_hit),
        .snp_upd_idx (sidx),
        .snp_upd_st  (s_nxt),
        .loc_upd_en  (upd_en),
        .loc_upd_idx (lidx),
        .loc_upd_st  (upd_st),
        .loc_upd_tag (upd_tag),
        .st_o        (st),
        .tag_o       (tag)
    );

endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lreq_valid,
    input logic              lreq_done,
    input logic              bus_req,
    input logic [1:0]        bus_op,
    input logic              bus_gnt,
    input logic              snp_valid,
    input logic [1:0]        snp_op,
    input logic              snp_shared,
    input logic              snp_dirty
);

    AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lreq_done |-> lreq_valid); // R5

    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lreq_done |=> !bus_req); // R2

    AST_FILL_GRANT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && (bus_op == 2'd0 || bus_op == 2'd1)) |-> lreq_done); // R3

    AST_UPG_GRANT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_op == 2'd2) |-> lreq_done); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && !snp_valid && lreq_valid) |=> bus_req); // R4

    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_op == 2'd3) |=> (bus_req && (bus_op == 2'd0 || bus_op == 2'd1))); // R8

    AST_WB_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        lreq_done |-> !(bus_req && bus_op == 2'd3)); // R8

    AST_SHARED_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared |-> (snp_valid && snp_op == 2'd0)); // R6

    AST_DIRTY_ON_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |-> snp_valid); // R7

    AST_SNOOP_GRANT_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(snp_valid && bus_gnt)); // R10

endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lreq_valid (lreq_valid),
    .lreq_done  (lreq_done),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_gnt    (bus_gnt),
    .snp_valid  (snp_valid),
    .snp_op     (snp_op),
    .snp_shared (snp_shared),
    .snp_dirty  (snp_dirty)
);

// File: tb/mesi_snoop_ctrl_test.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_test;

    localparam int ADDR_W = 8;
    localparam int NUM_LINES = 4;
    localparam int MAXCYC = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lreq_valid = 1'b0;
    logic              lreq_write = 1'b0;
    logic [ADDR_W-1:0] lreq_addr = '0;
    logic              lreq_done;
    logic              bus_req;
    logic [1:0]        bus_op;
    logic [ADDR_W-1:0] bus_addr;
    logic              bus_gnt = 1'b0;
    logic              bus_peer_shared = 1'b0;
    logic              snp_valid = 1'b0;
    logic [1:0]        snp_op = 2'd3;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic              snp_shared;
    logic              snp_dirty;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mesi_snoop_ctrl #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .lreq_valid(lreq_valid), .lreq_write(lreq_write), .lreq_addr(lreq_addr),
        .lreq_done(lreq_done),
        .bus_req(bus_req), .bus_op(bus_op), .bus_addr(bus_addr),
        .bus_gnt(bus_gnt), .bus_peer_shared(bus_peer_shared),
        .snp_valid(snp_valid), .snp_op(snp_op), .snp_addr(snp_addr),
        .snp_shared(snp_shared), .snp_dirty(snp_dirty)
    );

    // snoop=1: exp[1]=shared, exp[0]=dirty.
    // snoop=0: exp is the set of bus ops seen, bit n = bus_op n (0 rd,1 rdx,2 inv,3 wb).
    // race=1: snoop read-invalidate instead of the first grant.
    typedef struct packed {
        logic       snoop;
        logic       wr;
        logic [1:0] op;
        logic [7:0] addr;
        logic       psh;
        logic [1:0] race;
        logic [3:0] exp;
        logic [7:0] wba;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 21;
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0, 4'b0001, 8'h00, 4'd2}, // R2 read miss, fill E
        '{1'b1, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0, 4'b0010, 8'h00, 4'd6}, // R6 snoop read on E
        '{1'b0, 1'b1, 2'd0, 8'h10, 1'b0, 2'd0, 4'b0100, 8'h00, 4'd4}, // R4 write to S
        '{1'b1, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0, 4'b0011, 8'h00, 4'd6}, // R6 snoop read on M
        '{1'b0, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd5}, // R5 read hit on S
        '{1'b1, 1'b0, 2'd1, 8'h10, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd7}, // R7 rdinv on S
        '{1'b0, 1'b0, 2'd0, 8'h10, 1'b1, 2'd0, 4'b0001, 8'h00, 4'd2}, // R2 read miss, fill S
        '{1'b0, 1'b1, 2'd0, 8'h10, 1'b0, 2'd1, 4'b0110, 8'h00, 4'd4}, // R4 upgrade lost, retry rdx
        '{1'b1, 1'b0, 2'd0, 8'h10, 1'b0, 2'd0, 4'b0011, 8'h00, 4'd6}, // R6 line now M
        '{1'b0, 1'b1, 2'd0, 8'h21, 1'b0, 2'd0, 4'b0010, 8'h00, 4'd3}, // R3 write miss
        '{1'b0, 1'b1, 2'd0, 8'h21, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd5}, // R5 write hit on M
        '{1'b0, 1'b0, 2'd0, 8'h31, 1'b0, 2'd0, 4'b1001, 8'h21, 4'd8}, // R8 dirty victim
        '{1'b0, 1'b1, 2'd0, 8'h31, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd5}, // R5 silent E->M
        '{1'b1, 1'b0, 2'd2, 8'h31, 1'b0, 2'd0, 4'b0001, 8'h00, 4'd7}, // R7 inv on M
        '{1'b0, 1'b0, 2'd0, 8'h31, 1'b0, 2'd0, 4'b0001, 8'h00, 4'd7}, // R7 line is invalid
        '{1'b1, 1'b0, 2'd0, 8'h99, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd9}, // R9 tag mismatch
        '{1'b0, 1'b1, 2'd0, 8'h31, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd9}, // R9 line still E
        '{1'b0, 1'b0, 2'd0, 8'h12, 1'b0, 2'd0, 4'b0001, 8'h00, 4'd2}, // R2 fill E slot 2
        '{1'b0, 1'b1, 2'd0, 8'h22, 1'b0, 2'd0, 4'b0010, 8'h00, 4'd8}, // R8 clean victim
        '{1'b1, 1'b0, 2'd1, 8'h22, 1'b0, 2'd0, 4'b0001, 8'h00, 4'd7}, // R7 rdinv on M
        '{1'b1, 1'b0, 2'd0, 8'h12, 1'b0, 2'd0, 4'b0000, 8'h00, 4'd9}  // R9 replaced line
    };

    task automatic report(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_snoop(input logic [1:0] op, input logic [7:0] a,
                             output logic sh, output logic dr);
        @(negedge clk);
        snp_valid = 1'b1; snp_op = op; snp_addr = a;
        #0.3;
        sh = snp_shared; dr = snp_dirty;
        @(posedge clk);
        @(negedge clk);
        snp_valid = 1'b0; snp_op = 2'd3;
    endtask

    // race: 0 none, 1 rdinv snoop instead of first grant,
    //       2 snoop read with the request, 3 snoop rdinv with the request.
    task automatic run_local(input logic wr, input logic [7:0] a, input logic psh,
                             input logic [1:0] race,
                             output logic [3:0] mask, output logic [7:0] wba,
                             output int cyc, output logic s_sh, output logic s_dr);
        bit hold;
        mask = '0; wba = '0; cyc = 0; s_sh = 1'b0; s_dr = 1'b0;
        hold = (race == 2'd1);
        @(negedge clk);
        lreq_valid = 1'b1; lreq_write = wr; lreq_addr = a; bus_peer_shared = psh;
        if (race >= 2'd2) begin
            snp_valid = 1'b1; snp_op = (race == 2'd2) ? 2'd0 : 2'd1; snp_addr = a;
        end
        for (int k = 0; k < MAXCYC; k++) begin
            logic fin;
            #0.3;
            if (race >= 2'd2 && k == 0) begin
                s_sh = snp_shared; s_dr = snp_dirty;
            end
            if (bus_req) begin
                mask[bus_op] = 1'b1;
                if (bus_op == 2'd3) wba = bus_addr;
                if (hold) begin
                    hold = 1'b0;
                    snp_valid = 1'b1; snp_op = 2'd1; snp_addr = a;
                end else begin
                    bus_gnt = 1'b1;
                end
                #0.3;
            end
            fin = lreq_done;
            @(posedge clk);
            cyc++;
            @(negedge clk);
            bus_gnt = 1'b0; snp_valid = 1'b0; snp_op = 2'd3;
            if (fin) break;
        end
        lreq_valid = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_bad++;
                $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        logic [3:0] m;
        logic [7:0] w;
        int         c;
        logic       sh, dr;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet outputs and every slot invalid after reset
        #0.3;
        report("R1 bus_req after reset", {7'd0, bus_req}, 8'd0);
        report("R1 lreq_done after reset", {7'd0, lreq_done}, 8'd0);
        for (int i = 0; i < NUM_LINES; i++) begin
            run_snoop(2'd0, 8'(i), sh, dr);
            report("R1 snoop response after reset", {6'd0, sh, dr}, 8'd0);
        end

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            string tg;
            tg = $sformatf("R%0d vector %0d", VEC[v].req, v);
            if (VEC[v].snoop) begin
                run_snoop(VEC[v].op, VEC[v].addr, sh, dr);
                report(tg, {6'd0, sh, dr}, {4'd0, VEC[v].exp});
            end else begin
                run_local(VEC[v].wr, VEC[v].addr, VEC[v].psh, VEC[v].race, m, w, c, sh, dr);
                report(tg, {4'd0, m}, {4'd0, VEC[v].exp});
                report({tg, " completion"}, {7'd0, (c < MAXCYC)}, 8'd1);
                if (VEC[v].exp[3]) report({tg, " write-back address"}, w, VEC[v].wba);
            end
        end

        // R10: snoop read in the same cycle as a write to an exclusive line
        run_local(1'b0, 8'h13, 1'b0, 2'd0, m, w, c, sh, dr);
        report("R2 fill slot 3 exclusive", {4'd0, m}, 8'b0001);
        run_local(1'b1, 8'h13, 1'b0, 2'd2, m, w, c, sh, dr);
        report("R10 snoop response beside local write", {6'd0, sh, dr}, 8'b10);
        report("R10 write after snoop read needs invalidate", {4'd0, m}, 8'b0100);
        report("R10 write not silent", {7'd0, (c > 1)}, 8'd1);
        run_snoop(2'd0, 8'h13, sh, dr);
        report("R4 line modified after upgrade", {6'd0, sh, dr}, 8'b11);

        // R10: snoop read-invalidate in the same cycle as a read hit (slot 0 shared)
        run_local(1'b0, 8'h10, 1'b0, 2'd3, m, w, c, sh, dr);
        report("R10 snoop response beside local read", {6'd0, sh, dr}, 8'b00);
        report("R10 read refetches after invalidation", {4'd0, m}, 8'b0001);
        run_snoop(2'd0, 8'h10, sh, dr);
        report("R2 refilled line is clean and valid", {6'd0, sh, dr}, 8'b10);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule